// File: doc/BRIEF.md
# Event Performance Monitor Unit

This block counts processor activity for profiling. It holds one free-running cycle counter and two programmable event counters, all 32 bits wide. Each event counter watches one line of a 256-wide event bus, picked by an 8-bit code. Software reaches everything through a four-entry register port. Index 0 is a packed control word, and indices 1 to 3 are the counters.

When counting is enabled, the cycle counter advances on every clock. In a slow mode it advances only once per 64 enabled clocks. An event counter advances in every enabled cycle in which its chosen event line is high. When a counter wraps past its top value it sets a sticky overflow flag. The flag stays set until software writes a one to it. The single interrupt output is high while any flag is set together with its own enable bit.

Top module: `event_perf_monitor`

## Requirements
- R1: After reset the control word reads 0x0FFF_F000, meaning both event codes are 0xFF and every other field is 0. All three counters read 0 and `irq` is low.
- R2: Register index 0 is the control word, index 1 the cycle counter, index 2 event counter A and index 3 event counter B. Writing a counter index loads the written value, and the value can be read back at that index.
- R3: While the enable (control bit 0) is 1 and slow mode (bit 3) is 0, the cycle counter adds 1 on every clock. While the enable is 0, all three counters keep their values.
- R4: With the enable at 1 and bit 3 at 1, the cycle counter adds 1 once per 64 enabled clocks. The first step comes on the 64th enabled clock after the cycle counter was last cleared or written.
- R5: Event counter A takes its code from control bits 19:12 and counter B from bits 27:20. Each adds 1 on a clock where the enable is 1 and the event line its code selects is high.
- R6: A counter whose code is 0xFF never counts, even when event line 255 is high.
- R7: Writing control bit 1 as 1 zeroes both event counters, and writing bit 2 as 1 zeroes the cycle counter. Neither bit is stored.
- R8: A counter that steps from 0xFFFF_FFFF goes to 0 and keeps counting. The step also sets its overflow flag: bit 8 for A, bit 9 for B, bit 10 for the cycle counter.
- R9: A flag is cleared only by writing a 1 to its own bit, and writing a 0 to it has no effect. A flag set on one counter never clears the flag of another. If a wrap and a clear-write hit the same flag in the same cycle, the flag ends up set.
- R10: Bits 4, 5 and 6 are the interrupt enables for A, B and the cycle counter. `irq` equals the OR, over the three counters, of each flag ANDed with its enable.
- R11: Control bits 1, 2, 7, 11 and 31:28 always read as 0, whatever is written.
- R12: A write to a counter index takes priority over that counter's increment in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register index for reads and writes |
| reg_wr | input | 1 | Write strobe, one write per clock |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_lines | input | LINES (256) | Event inputs, one per code |
| irq | output | 1 | Level interrupt |

## Verification
The checker watches these rules on every cycle:
- Counters hold while the enable is off.
- In fast mode the cycle counter steps by exactly one.
- Clear writes take effect, and a wrap raises its flag.
- Flags stay set unless their own bit is written as 1.
- A code of 0xFF freezes its counter, and a load wins over a step.
- `irq` never rises with no flag set, and the reserved bits always read 0.

Other behaviours need the bench's scenarios and its behavioural model:
- The exact 64-clock timing of slow mode.
- Event selection against the event lines.
- A flag's set winning over its clear in the same cycle.
- Two flags coexisting after separate overflows.

// File: rtl/evpmu_pkg.sv
package evpmu_pkg;
   localparam int unsigned N_EVT    = 2;
   localparam int unsigned N_SLOT   = N_EVT + 1;
   localparam int unsigned SLOT_CYC = N_EVT;
   localparam int unsigned CODE_W   = 8;
   localparam logic [CODE_W-1:0] CODE_NONE = 8'hFF;

   localparam int unsigned B_EN     = 0;
   localparam int unsigned B_CLR_EV = 1;
   localparam int unsigned B_CLR_CY = 2;
   localparam int unsigned B_SLOW   = 3;
   localparam int unsigned IEN_LO   = 4;
   localparam int unsigned FLG_LO   = 8;
   localparam int unsigned CODE_LO  = 12;

   localparam logic [31:0] RD_ZERO_MASK = 32'hF000_0886;

   typedef enum logic [1:0] {
      IDX_CTRL = 2'd0,
      IDX_CYC  = 2'd1,
      IDX_EVA  = 2'd2,
      IDX_EVB  = 2'd3
   } reg_idx_e;

   typedef struct packed {
      logic                         en;
      logic                         slow;
      logic                         clr_ev;
      logic                         clr_cy;
      logic [N_SLOT-1:0]            ien;
      logic [N_SLOT-1:0]            fclr;
      logic [N_EVT-1:0][CODE_W-1:0] codes;
   } ctrl_wr_t;
endpackage

// File: rtl/evpmu_counter.sv
module evpmu_counter #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         clr,
   input  logic         step,
   output logic [W-1:0] value,
   output logic         wrap
);
   localparam logic [W-1:0] TOP = '1;

   assign wrap = step && !ld && !clr && (value == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    value <= '0;
      else if (ld)   value <= ld_val;
      else if (clr)  value <= '0;
      else if (step) value <= value + W'(1);
   end
endmodule

// File: rtl/evpmu_evsel.sv
module evpmu_evsel
   import evpmu_pkg::*;
#(
   parameter int unsigned LINES = 256
) (
   input  logic [CODE_W-1:0] code,
   input  logic [LINES-1:0]  lines,
   output logic              hit
);
   logic picked;

   always_comb begin
      picked = 1'b0;
      for (int i = 0; i < LINES; i++) begin
         if (code == CODE_W'(i)) picked = lines[i];
      end
   end

   assign hit = picked && (code != CODE_NONE);
endmodule

// File: rtl/evpmu_prescale.sv
module evpmu_prescale #(
   parameter int unsigned DIV = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [DW-1:0] LAST = DW'(DIV - 1);
   localparam bit POW2 = ((DIV & (DIV - 1)) == 0);

   logic [DW-1:0] cnt;

   assign tick = run && (cnt == LAST);

   generate
      if (POW2) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt <= '0;
            else if (restart) cnt <= '0;
            else if (run)     cnt <= cnt + DW'(1);
         end
      end else begin : g_any
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt <= '0;
            else if (restart) cnt <= '0;
            else if (run)     cnt <= tick ? '0 : cnt + DW'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/evpmu_ctrl.sv
module evpmu_ctrl
   import evpmu_pkg::*;
(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr,
   input  ctrl_wr_t                     fld,
   input  logic [N_SLOT-1:0]            wrap,
   output logic                         en,
   output logic                         slow,
   output logic [N_SLOT-1:0]            ien,
   output logic [N_SLOT-1:0]            flags,
   output logic [N_EVT-1:0][CODE_W-1:0] codes,
   output logic                         clr_ev,
   output logic                         clr_cy,
   output logic [31:0]                  rd_val,
   output logic                         irq
);
   logic [N_SLOT-1:0] fclr_eff;

   assign clr_ev   = wr && fld.clr_ev;
   assign clr_cy   = wr && fld.clr_cy;
   assign fclr_eff = wr ? fld.fclr : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en    <= 1'b0;
         slow  <= 1'b0;
         ien   <= '0;
         codes <= {N_EVT{CODE_NONE}};
      end else if (wr) begin
         en    <= fld.en;
         slow  <= fld.slow;
         ien   <= fld.ien;
         codes <= fld.codes;
      end
   end

   // a wrap in the same cycle as a clear-write wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~fclr_eff) | wrap;
   end

   assign irq = |(flags & ien);

   always_comb begin
      rd_val = '0;
      rd_val[B_EN]                         = en;
      rd_val[B_SLOW]                       = slow;
      rd_val[IEN_LO +: N_SLOT]             = ien;
      rd_val[FLG_LO +: N_SLOT]             = flags;
      rd_val[CODE_LO +: (N_EVT * CODE_W)]  = codes;
   end
endmodule

// File: rtl/event_perf_monitor.sv
module event_perf_monitor
   import evpmu_pkg::*;
#(
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned LINES    = 256,
   parameter int unsigned PRESCALE = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [LINES-1:0]  evt_lines,
   output logic              irq
);
   generate
      if (CNT_W < 8 || CNT_W > 32) begin : g_bad_w
         $error("CNT_W must lie in 8..32");
      end
      if (LINES < 1 || LINES > 256) begin : g_bad_lines
         $error("LINES must lie in 1..256");
      end
      if (PRESCALE < 2) begin : g_bad_div
         $error("PRESCALE must be at least 2");
      end
   endgenerate

   ctrl_wr_t                     wfld;
   logic                         wr_ctrl;
   logic [N_SLOT-1:0]            wr_slot;
   logic                         ctl_en, ctl_slow, clr_ev, clr_cy, tick;
   logic [N_SLOT-1:0]            ctl_ien, flags, step, clr, wrap;
   logic [N_EVT-1:0][CODE_W-1:0] codes;
   logic [N_EVT-1:0]             hit;
   logic [CNT_W-1:0]             cnt [N_SLOT];
   logic [CNT_W-1:0]             cyc_cnt, eva_cnt;
   logic [31:0]                  ctrl_rd;

   assign wr_ctrl     = reg_wr && (reg_addr == IDX_CTRL);
   assign wfld.en     = reg_wdata[B_EN];
   assign wfld.slow   = reg_wdata[B_SLOW];
   assign wfld.clr_ev = reg_wdata[B_CLR_EV];
   assign wfld.clr_cy = reg_wdata[B_CLR_CY];
   assign wfld.ien    = reg_wdata[IEN_LO +: N_SLOT];
   assign wfld.fclr   = reg_wdata[FLG_LO +: N_SLOT];
   assign wfld.codes  = reg_wdata[CODE_LO +: (N_EVT * CODE_W)];

   evpmu_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_ctrl),
      .fld    (wfld),
      .wrap   (wrap),
      .en     (ctl_en),
      .slow   (ctl_slow),
      .ien    (ctl_ien),
      .flags  (flags),
      .codes  (codes),
      .clr_ev (clr_ev),
      .clr_cy (clr_cy),
      .rd_val (ctrl_rd),
      .irq    (irq)
   );

   evpmu_prescale #(.DIV(PRESCALE)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctl_en && ctl_slow),
      .restart (clr[SLOT_CYC] || wr_slot[SLOT_CYC]),
      .tick    (tick)
   );

   genvar k;
   generate
      for (k = 0; k < N_EVT; k++) begin : g_evt
         evpmu_evsel #(.LINES(LINES)) u_sel (
            .code  (codes[k]),
            .lines (evt_lines),
            .hit   (hit[k])
         );
         assign step[k]    = ctl_en && hit[k];
         assign clr[k]     = clr_ev;
         assign wr_slot[k] = reg_wr && (reg_addr == 2'(int'(IDX_EVA) + k));
      end
   endgenerate

   assign step[SLOT_CYC]    = ctl_en && (ctl_slow ? tick : 1'b1);
   assign clr[SLOT_CYC]     = clr_cy;
   assign wr_slot[SLOT_CYC] = reg_wr && (reg_addr == IDX_CYC);

   generate
      for (k = 0; k < N_SLOT; k++) begin : g_cnt
         evpmu_counter #(.W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (wr_slot[k]),
            .ld_val (reg_wdata[CNT_W-1:0]),
            .clr    (clr[k]),
            .step   (step[k]),
            .value  (cnt[k]),
            .wrap   (wrap[k])
         );
      end
   endgenerate

   assign cyc_cnt = cnt[SLOT_CYC];
   assign eva_cnt = cnt[0];

   always_comb begin
      case (reg_addr)
         IDX_CTRL: reg_rdata = ctrl_rd;
         IDX_CYC:  reg_rdata = 32'(cnt[SLOT_CYC]);
         IDX_EVA:  reg_rdata = 32'(cnt[0]);
         default:  reg_rdata = 32'(cnt[1]);
      endcase
   end
endmodule

// File: rtl/evpmu_checker.sv
module evpmu_checker
   import evpmu_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        reg_addr,
   input logic              reg_wr,
   input logic [31:0]       reg_wdata,
   input logic [31:0]       reg_rdata,
   input logic              irq,
   input logic              en,
   input logic              slow,
   input logic [N_SLOT-1:0] flags,
   input logic [CODE_W-1:0] code_a,
   input logic [CNT_W-1:0]  cyc_cnt,
   input logic [CNT_W-1:0]  eva_cnt
);
   localparam logic [CNT_W-1:0] TOP = '1;

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !reg_wr) |=> ($stable(cyc_cnt) && $stable(eva_cnt)));

   p_fast_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !slow && !reg_wr) |=> (cyc_cnt == $past(cyc_cnt) + CNT_W'(1)));

   p_cyc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd0 && reg_wdata[B_CLR_CY]) |=> (cyc_cnt == '0));

   p_wrap_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !slow && !reg_wr && cyc_cnt == TOP) |=> (flags[SLOT_CYC] && cyc_cnt == '0));

   genvar i;
   generate
      for (i = 0; i < N_SLOT; i++) begin : g_sticky
         p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !(reg_wr && reg_addr == 2'd0 && reg_wdata[FLG_LO + i])) |=> flags[i]);
      end
   endgenerate

   p_no_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (code_a == CODE_NONE && !reg_wr) |=> $stable(eva_cnt));

   p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flags != '0));

   p_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 2'd0) |-> ((reg_rdata & RD_ZERO_MASK) == 32'd0));

   p_load_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd2) |=> (eva_cnt == $past(reg_wdata[CNT_W-1:0])));
endmodule

bind event_perf_monitor evpmu_checker #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .irq       (irq),
   .en        (ctl_en),
   .slow      (ctl_slow),
   .flags     (flags),
   .code_a    (codes[0]),
   .cyc_cnt   (cyc_cnt),
   .eva_cnt   (eva_cnt)
);

// File: tb/event_perf_monitor_test.sv
`timescale 1ns/1ps
module event_perf_monitor_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   reg_addr = 2'd0;
   logic         reg_wr = 1'b0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic [255:0] evt_lines = '0;
   logic         irq;

   int checks = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   event_perf_monitor uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_lines(evt_lines), .irq(irq)
   );

   // behavioural reference: m_c[0]=A, m_c[1]=B, m_c[2]=cycle
   bit [31:0] m_c [3] = '{0, 0, 0};
   bit        m_en = 0, m_slow = 0;
   bit [2:0]  m_ien = 0, m_flag = 0;
   bit [7:0]  m_code [2] = '{8'hFF, 8'hFF};
   int        m_div = 0;

   function automatic bit [31:0] model_read(input bit [1:0] a);
      case (a)
         2'd0: return {4'b0, m_code[1], m_code[0], 1'b0, m_flag, 1'b0, m_ien, m_slow, 2'b0, m_en};
         2'd1: return m_c[2];
         2'd2: return m_c[0];
         default: return m_c[1];
      endcase
   endfunction

   always @(posedge clk) begin
      bit [2:0] stp;
      bit [2:0] wr_ov;
      bit       cw;
      cw = reg_wr && reg_addr == 2'd0;
      if (!rst_n) begin
         m_c = '{0, 0, 0}; m_en = 0; m_slow = 0; m_ien = 0; m_flag = 0;
         m_code = '{8'hFF, 8'hFF}; m_div = 0;
      end else begin
         stp[2] = m_en && (!m_slow || m_div == 63);
         for (int k = 0; k < 2; k++)
            stp[k] = m_en && m_code[k] != 8'hFF && evt_lines[m_code[k]];
         wr_ov = 0;
         for (int s = 0; s < 3; s++) begin
            int a;
            bit zap;
            a   = (s == 2) ? 1 : s + 2;
            zap = cw && ((s < 2) ? reg_wdata[1] : reg_wdata[2]);
            if (reg_wr && reg_addr == 2'(a)) m_c[s] = reg_wdata;
            else if (zap) m_c[s] = 0;
            else if (stp[s]) begin
               if (m_c[s] == 32'hFFFF_FFFF) wr_ov[s] = 1;
               m_c[s] = m_c[s] + 1;
            end
         end
         if (reg_wr && (reg_addr == 2'd1 || (cw && reg_wdata[2]))) m_div = 0;
         else if (m_en && m_slow) m_div = (m_div + 1) % 64;
         if (cw) m_flag = m_flag & ~reg_wdata[10:8];
         m_flag = m_flag | wr_ov;
         if (cw) begin
            m_en = reg_wdata[0]; m_slow = reg_wdata[3]; m_ien = reg_wdata[6:4];
            m_code[0] = reg_wdata[19:12]; m_code[1] = reg_wdata[27:20];
         end
      end
   end

   // per-cycle comparison against the model
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         checks++;
         if (reg_rdata !== model_read(reg_addr)) begin
            bad++;
            $display("FAIL R2 cycle compare idx=%0d act=%h exp=%h", reg_addr, reg_rdata, model_read(reg_addr));
         end
         checks++;
         if (irq !== |(m_flag & m_ien)) begin
            bad++;
            $display("FAIL R10 cycle compare irq act=%b exp=%b", irq, |(m_flag & m_ien));
         end
      end
   end

   function automatic bit [31:0] mk(input bit en, input bit slow, input bit [2:0] ien,
                                    input bit [7:0] ca, input bit [7:0] cb,
                                    input bit cev, input bit ccy, input bit [2:0] fclr);
      return {4'b0, cb, ca, 1'b0, fclr, 1'b0, ien, slow, ccy, cev, en};
   endfunction

   task automatic put(input bit [1:0] a, input bit [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd_chk(input string tag, input bit [1:0] a, input bit [31:0] exp);
      reg_addr = a;
      #0.5;
      checks++;
      if (reg_rdata !== exp) begin
         bad++;
         $display("FAIL %s idx=%0d act=%h exp=%h", tag, a, reg_rdata, exp);
      end
   endtask

   task automatic irq_chk(input string tag, input bit exp);
      #0.2;
      checks++;
      if (irq !== exp) begin
         bad++;
         $display("FAIL %s irq act=%b exp=%b", tag, irq, exp);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd_chk("R1", 2'd0, 32'h0FFF_F000);
      rd_chk("R1", 2'd1, 0);
      rd_chk("R1", 2'd2, 0);
      rd_chk("R1", 2'd3, 0);
      irq_chk("R1", 0);
      // R2 register map and load
      put(2'd2, 32'h1234); put(2'd3, 32'hABCD); put(2'd1, 32'h10);
      rd_chk("R2", 2'd2, 32'h1234);
      rd_chk("R2", 2'd3, 32'hABCD);
      rd_chk("R2", 2'd1, 32'h10);
      // R3 fast counting, then hold
      put(2'd0, mk(1, 0, 0, 8'hFF, 8'hFF, 0, 0, 0));
      idle(9);
      put(2'd0, mk(0, 0, 0, 8'hFF, 8'hFF, 0, 0, 0));
      rd_chk("R3", 2'd1, 32'h1A);
      idle(5);
      rd_chk("R3", 2'd1, 32'h1A);
      rd_chk("R6", 2'd2, 32'h1234);
      // R5 event selection
      put(2'd0, mk(1, 0, 0, 8'h05, 8'h07, 0, 0, 0));
      evt_lines[5] = 1; evt_lines[7] = 1;
      idle(3);
      evt_lines[7] = 0;
      idle(3);
      evt_lines = '0;
      put(2'd0, mk(0, 0, 0, 8'h05, 8'h07, 0, 0, 0));
      rd_chk("R5", 2'd2, 32'h123A);
      rd_chk("R5", 2'd3, 32'hABD0);
      // R6 code 0xFF ignores line 255
      put(2'd0, mk(1, 0, 0, 8'hFF, 8'h07, 0, 0, 0));
      evt_lines[255] = 1;
      idle(4);
      evt_lines = '0;
      put(2'd0, mk(0, 0, 0, 8'hFF, 8'hFF, 0, 0, 0));
      rd_chk("R6", 2'd2, 32'h123A);
      // R7 clears
      put(2'd0, mk(0, 0, 0, 8'hFF, 8'hFF, 1, 0, 0));
      rd_chk("R7", 2'd2, 0);
      rd_chk("R7", 2'd3, 0);
      put(2'd0, mk(0, 0, 0, 8'hFF, 8'hFF, 0, 1, 0));
      rd_chk("R7", 2'd1, 0);
      rd_chk("R7", 2'd0, 32'h0FFF_F000);
      // R8 cycle wrap
      put(2'd1, 32'hFFFF_FFFE);
      put(2'd0, mk(1, 0, 0, 8'hFF, 8'hFF, 0, 0, 0));
      idle(2);
      put(2'd0, mk(0, 0, 0, 8'hFF, 8'hFF, 0, 0, 0));
      rd_chk("R8", 2'd1, 1);
      rd_chk("R8", 2'd0, 32'h0FFF_F400);
      irq_chk("R10", 0);
      put(2'd0, mk(0, 0, 3'b100, 8'hFF, 8'hFF, 0, 0, 0));
      irq_chk("R10", 1);
      // R9 writing zero keeps the flag; a second overflow keeps the first flag
      put(2'd0, mk(0, 0, 3'b100, 8'hFF, 8'hFF, 0, 0, 0));
      rd_chk("R9", 2'd0, 32'h0FFF_F440);
      put(2'd2, 32'hFFFF_FFFF);
      put(2'd0, mk(1, 0, 3'b100, 8'h05, 8'hFF, 0, 0, 0));
      evt_lines[5] = 1;
      idle(1);
      evt_lines = '0;
      put(2'd0, mk(0, 0, 3'b100, 8'h05, 8'hFF, 0, 0, 0));
      rd_chk("R8", 2'd2, 0);
      rd_chk("R9", 2'd0, 32'h0FF0_5540);
      put(2'd0, mk(0, 0, 3'b100, 8'h05, 8'hFF, 0, 0, 3'b100));
      rd_chk("R9", 2'd0, 32'h0FF0_5140);
      irq_chk("R10", 0);
      put(2'd0, mk(0, 0, 3'b101, 8'h05, 8'hFF, 0, 0, 0));
      irq_chk("R10", 1);
      put(2'd0, mk(0, 0, 3'b101, 8'h05, 8'hFF, 0, 0, 3'b001));
      rd_chk("R9", 2'd0, 32'h0FF0_5050);
      irq_chk("R10", 0);
      // R9 set wins over clear in the same cycle
      put(2'd2, 32'hFFFF_FFFF);
      put(2'd0, mk(1, 0, 0, 8'h05, 8'hFF, 0, 0, 0));
      evt_lines[5] = 1;
      put(2'd0, mk(1, 0, 0, 8'h05, 8'hFF, 0, 0, 3'b001));
      evt_lines = '0;
      put(2'd0, mk(0, 0, 0, 8'h05, 8'hFF, 0, 0, 0));
      rd_chk("R9", 2'd0, 32'h0FF0_5100);
      rd_chk("R8", 2'd2, 0);
      // R11 reserved and action bits read zero
      put(2'd0, 32'hFFFF_FFFF);
      rd_chk("R11", 2'd0, 32'h0FFF_F079);
      irq_chk("R11", 0);
      put(2'd0, mk(0, 0, 0, 8'hFF, 8'hFF, 0, 0, 0));
      // R12 write beats increment
      put(2'd0, mk(1, 0, 0, 8'hFF, 8'hFF, 0, 0, 0));
      put(2'd1, 32'd100);
      rd_chk("R12", 2'd1, 32'd100);
      put(2'd0, mk(0, 0, 0, 8'hFF, 8'hFF, 0, 0, 0));
      rd_chk("R12", 2'd1, 32'd101);
      // R4 slow mode
      put(2'd0, mk(0, 1, 0, 8'hFF, 8'hFF, 0, 1, 0));
      put(2'd0, mk(1, 1, 0, 8'hFF, 8'hFF, 0, 0, 0));
      idle(63);
      rd_chk("R4", 2'd1, 0);
      idle(1);
      rd_chk("R4", 2'd1, 1);
      idle(64);
      put(2'd0, mk(0, 1, 0, 8'hFF, 8'hFF, 0, 0, 0));
      rd_chk("R4", 2'd1, 2);
      idle(2);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         checks++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule